// File: doc/BRIEF.md
# Data Address Generation Unit

This unit sits beside the load/store path of a small 8-bit core. For each data access it computes the 16-bit effective address from one of five addressing modes. The modes are a direct 16-bit operand, a plain pointer, a pointer plus a 6-bit unsigned offset, a pointer decremented before use, and a pointer used and then incremented. When a mode changes a pointer, the unit writes the new pointer value back. It then sorts the address into one of four regions of the data space and drives the matching select line, together with the offset of the address inside that region.

The three 16-bit pointers are built from six byte registers at register-file addresses 26 to 31. Each pointer takes the low byte at the even address and the high byte at the odd address. The unit keeps these six bytes itself, so a store to one of those addresses reloads a pointer byte. Every access result is registered. An access that lands in SRAM takes two cycles: the unit stalls the core for one cycle and holds its outputs for that time. Every other access takes a single cycle.

Top module: `data_addr_unit`

## Requirements
- R1: An accepted access to an address below 0x0900 raises exactly one bit of `acc_sel`, where bit 0 is the register file (0x0000–0x001F), bit 1 is standard I/O (0x0020–0x005F), bit 2 is extended I/O (0x0060–0x00FF) and bit 3 is SRAM (0x0100–0x08FF). `acc_offset` is the address minus the start of its region.
- R2: An address from 0x0900 to 0xFFFF sets `acc_oor`, raises no bit of `acc_sel`, and forces `core_rdata` to zero. Otherwise `core_rdata` passes `fab_rdata` through unchanged.
- R3: In direct mode (`req_mode` 0) the effective address is `req_addr`, and no pointer changes except through R8.
- R4: In indirect mode (`req_mode` 1) the effective address is the pointer that `req_ptr` selects (0 = X, 1 = Y, 2 = Z), and that pointer is left unchanged.
- R5: In displacement mode (`req_mode` 2) with Y or Z selected, the effective address is the pointer plus the zero-extended `req_disp` (0–63), taken modulo 2^16. With X selected, the displacement is ignored and the address is X.
- R6: In pre-decrement mode (`req_mode` 3) the pointer is reduced by one modulo 2^16. The reduced value is the effective address and is written back, so 0x0000 becomes 0xFFFF.
- R7: In post-increment mode (`req_mode` 4) the old pointer value is the effective address, and the pointer is written back as that value plus one modulo 2^16, so 0xFFFF becomes 0x0000.
- R8: An accepted store (`req_write` = 1) to an address from 26 to 31 loads `req_wdata` into that pointer byte. Address 26 is X low, 27 is X high, 28 is Y low, 29 is Y high, 30 is Z low and 31 is Z high.
- R9: When a store under R8 targets a byte of the pointer that the same access writes back under R6 or R7, the write-back value wins.
- R10: After an accepted SRAM access, `stall` is high for exactly one cycle and `req_ready` is low for that cycle. A request presented during that cycle is not accepted, and the access outputs stay unchanged.
- R11: An accepted access outside SRAM never raises `stall`.
- R12: After reset, all pointers read 0 and `acc_valid`, `acc_sel`, `acc_oor` and `stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_mode | input | 3 | Addressing mode: 0 direct, 1 indirect, 2 displacement, 3 pre-decrement, 4 post-increment |
| req_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| req_disp | input | 6 | Unsigned displacement |
| req_addr | input | 16 | Direct address operand |
| req_write | input | 1 | Access is a store |
| req_wdata | input | 8 | Store data |
| fab_rdata | input | 8 | Read data returned by the selected region |
| req_ready | output | 1 | Request can be accepted this cycle |
| acc_valid | output | 1 | Registered access outputs are live |
| acc_write | output | 1 | Registered store flag |
| acc_wdata | output | 8 | Registered store data |
| acc_addr | output | 16 | Registered effective address |
| acc_sel | output | 4 | One-hot region select |
| acc_offset | output | 11 | Offset inside the selected region |
| acc_oor | output | 1 | Address beyond the last region |
| stall | output | 1 | First cycle of a two-cycle SRAM access |
| core_rdata | output | 8 | Read data to the core, zero when out of range |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |
| ptr_z | output | 16 | Pointer Z |

## Verification
The unit accepts a request at a clock edge. The effective address, select, offset, out-of-range flag and stall are all valid right after that edge, and so is the pointer write-back, because pointer and output registers load at the same edge. The bench drives each request at a falling edge and samples one falling edge later, which is exactly one register stage after acceptance. After an SRAM access it presents a competing request during the stall cycle and samples again one falling edge later, to confirm that the outputs held and the stall dropped after a single cycle.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int DISP_W    = 6;
  localparam int REG_CNT   = 32;
  localparam int IO_CNT    = 64;
  localparam int EXT_CNT   = 160;
  localparam int SRAM_CNT  = 2048;
  localparam int PTR_FIRST = 26;
  localparam int NPTR      = 3;
  localparam int NREGION   = 4;

  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } amode_t;
endpackage

// File: rtl/dau_ptr_file.sv
module dau_ptr_file #(
  parameter int DATA_W = 8,
  parameter int NPTR   = 3,
  localparam int PW    = 2 * DATA_W,
  localparam int NB    = 2 * NPTR,
  localparam int IDX_W = $clog2(NB),
  localparam int SEL_W = $clog2(NPTR)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wb_en,
  input  logic [SEL_W-1:0]           wb_sel,
  input  logic [PW-1:0]              wb_val,
  input  logic                       st_en,
  input  logic [IDX_W-1:0]           st_idx,
  input  logic [DATA_W-1:0]          st_data,
  output logic [NPTR-1:0][PW-1:0]    ptrs
);
  logic [DATA_W-1:0] bytes_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [SEL_W-1:0] OWNER = SEL_W'(b / 2);
    localparam logic [IDX_W-1:0] MYIDX = IDX_W'(b);
    logic [DATA_W-1:0] wb_byte;
    if (b % 2 == 0) begin : g_lo
      assign wb_byte = wb_val[DATA_W-1:0];
    end else begin : g_hi
      assign wb_byte = wb_val[PW-1:DATA_W];
    end
    always_ff @(posedge clk) begin
      if (rst)
        bytes_q[b] <= '0;
      else if (wb_en && wb_sel == OWNER)
        bytes_q[b] <= wb_byte;
      else if (st_en && st_idx == MYIDX)
        bytes_q[b] <= st_data;
    end
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptrs[p] = {bytes_q[2*p+1], bytes_q[2*p]};
  end
endmodule

// File: rtl/dau_ea_calc.sv
module dau_ea_calc
  import dau_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input  logic [2:0]    mode,
  input  logic          base_is_x,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] dir_addr,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] new_ptr,
  output logic          wb
);
  always_comb begin
    ea      = base;
    new_ptr = base;
    wb      = 1'b0;
    case (mode)
      AM_DIRECT:  ea = dir_addr;
      AM_IND:     ea = base;
      AM_DISP:    ea = base_is_x ? base : base + AW'(disp);
      AM_PREDEC: begin
        new_ptr = base - AW'(1);
        ea      = new_ptr;
        wb      = 1'b1;
      end
      AM_POSTINC: begin
        new_ptr = base + AW'(1);
        ea      = base;
        wb      = 1'b1;
      end
      default:    ea = base;
    endcase
  end
endmodule

// File: rtl/dau_region_dec.sv
module dau_region_dec #(
  parameter int AW       = 16,
  parameter int REG_CNT  = 32,
  parameter int IO_CNT   = 64,
  parameter int EXT_CNT  = 160,
  parameter int SRAM_CNT = 2048,
  localparam int NR      = 4,
  localparam int OFS_W   = $clog2(SRAM_CNT)
) (
  input  logic [AW-1:0]    ea,
  output logic [NR-1:0]    sel,
  output logic [OFS_W-1:0] offset,
  output logic             oor
);
  localparam int BASE [NR] = '{0, REG_CNT, REG_CNT + IO_CNT, REG_CNT + IO_CNT + EXT_CNT};
  localparam int SIZE [NR] = '{REG_CNT, IO_CNT, EXT_CNT, SRAM_CNT};

  logic [NR-1:0][OFS_W-1:0] ofs_r;

  for (genvar i = 0; i < NR; i++) begin : g_reg
    logic [AW-1:0] rel;
    assign rel      = ea - AW'(BASE[i]);
    assign sel[i]   = rel < AW'(SIZE[i]);
    assign ofs_r[i] = sel[i] ? rel[OFS_W-1:0] : '0;
  end

  always_comb begin
    offset = '0;
    for (int i = 0; i < NR; i++) offset = offset | ofs_r[i];
  end

  assign oor = ~|sel;
endmodule

// File: rtl/data_addr_unit.sv
module data_addr_unit
  import dau_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int DW        = DATA_W,
  parameter int DSW       = DISP_W,
  parameter int N_REG     = REG_CNT,
  parameter int N_IO      = IO_CNT,
  parameter int N_EXT     = EXT_CNT,
  parameter int N_SRAM    = SRAM_CNT,
  parameter int PTR_BASE  = PTR_FIRST,
  localparam int OFS_W    = $clog2(N_SRAM),
  localparam int NB       = 2 * NPTR,
  localparam int IDX_W    = $clog2(NB),
  localparam int SEL_W    = $clog2(NPTR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic [1:0]       req_ptr,
  input  logic [DSW-1:0]   req_disp,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    fab_rdata,
  output logic             req_ready,
  output logic             acc_valid,
  output logic             acc_write,
  output logic [DW-1:0]    acc_wdata,
  output logic [AW-1:0]    acc_addr,
  output logic [3:0]       acc_sel,
  output logic [OFS_W-1:0] acc_offset,
  output logic             acc_oor,
  output logic             stall,
  output logic [DW-1:0]    core_rdata,
  output logic [AW-1:0]    ptr_x,
  output logic [AW-1:0]    ptr_y,
  output logic [AW-1:0]    ptr_z
);
  logic                      accept;
  logic [SEL_W-1:0]          psel;
  logic [NPTR-1:0][AW-1:0]   ptrs;
  logic [AW-1:0]             base, ea, new_ptr, st_rel;
  logic                      calc_wb, st_hit;
  logic [3:0]                sel_d;
  logic [OFS_W-1:0]          ofs_d;
  logic                      oor_d;

  assign accept = req_valid && !stall;
  assign psel   = (req_ptr > 2'(NPTR - 1)) ? SEL_W'(NPTR - 1) : SEL_W'(req_ptr);
  assign base   = ptrs[psel];

  dau_ea_calc #(.AW(AW), .DW(DSW)) u_ea (
    .mode      (req_mode),
    .base_is_x (psel == '0),
    .base      (base),
    .disp      (req_disp),
    .dir_addr  (req_addr),
    .ea        (ea),
    .new_ptr   (new_ptr),
    .wb        (calc_wb)
  );

  assign st_rel = ea - AW'(PTR_BASE);
  assign st_hit = st_rel < AW'(NB);

  dau_ptr_file #(.DATA_W(DW), .NPTR(NPTR)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .wb_en   (accept && calc_wb),
    .wb_sel  (psel),
    .wb_val  (new_ptr),
    .st_en   (accept && req_write && st_hit),
    .st_idx  (st_rel[IDX_W-1:0]),
    .st_data (req_wdata),
    .ptrs    (ptrs)
  );

  dau_region_dec #(
    .AW(AW), .REG_CNT(N_REG), .IO_CNT(N_IO), .EXT_CNT(N_EXT), .SRAM_CNT(N_SRAM)
  ) u_dec (
    .ea     (ea),
    .sel    (sel_d),
    .offset (ofs_d),
    .oor    (oor_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid  <= 1'b0;
      acc_write  <= 1'b0;
      acc_wdata  <= '0;
      acc_addr   <= '0;
      acc_sel    <= '0;
      acc_offset <= '0;
      acc_oor    <= 1'b0;
      stall      <= 1'b0;
    end else if (accept) begin
      acc_valid  <= 1'b1;
      acc_write  <= req_write;
      acc_wdata  <= req_wdata;
      acc_addr   <= ea;
      acc_sel    <= sel_d;
      acc_offset <= ofs_d;
      acc_oor    <= oor_d;
      stall      <= sel_d[3];
    end else if (stall) begin
      stall      <= 1'b0;
    end else begin
      acc_valid  <= 1'b0;
    end
  end

  assign req_ready  = !stall;
  assign core_rdata = acc_oor ? '0 : fab_rdata;
  assign ptr_x      = ptrs[0];
  assign ptr_y      = ptrs[1];
  assign ptr_z      = ptrs[2];
endmodule

// File: rtl/data_addr_unit_chk.sv
module data_addr_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [2:0]  req_mode,
  input logic [1:0]  req_ptr,
  input logic        stall,
  input logic        acc_valid,
  input logic [3:0]  acc_sel,
  input logic        acc_oor,
  input logic [15:0] acc_addr,
  input logic [15:0] ptr_x
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot0(acc_sel));
  p_inrange_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_oor) |-> ($countones(acc_sel) == 1));
  p_oor_nosel_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_oor) |-> (acc_sel == 4'b0000));
  p_predec_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stall && req_mode == 3'd3 && req_ptr == 2'd0) |=> (acc_addr == ptr_x));
  p_postinc_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stall && req_mode == 3'd4 && req_ptr == 2'd0) |=> (ptr_x == $past(ptr_x) + 16'd1));
  p_stall_once_r10: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);
  p_stall_sram_r10: assert property (@(posedge clk) disable iff (rst)
    stall |-> acc_sel[3]);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(acc_addr));
  p_nostall_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_sel[3]) |-> !stall);
endmodule

bind data_addr_unit data_addr_unit_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
  .req_ptr(req_ptr), .stall(stall), .acc_valid(acc_valid), .acc_sel(acc_sel),
  .acc_oor(acc_oor), .acc_addr(acc_addr), .ptr_x(ptr_x)
);

// File: tb/data_addr_unit_bench.sv
`timescale 1ns/1ps
module data_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic [1:0]  req_ptr = 2'd0;
  logic [5:0]  req_disp = 6'd0;
  logic [15:0] req_addr = 16'd0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = 8'd0;
  logic [7:0]  fab_rdata = 8'hA5;
  logic        req_ready, acc_valid, acc_write, acc_oor, stall;
  logic [7:0]  acc_wdata, core_rdata;
  logic [15:0] acc_addr, ptr_x, ptr_y, ptr_z;
  logic [3:0]  acc_sel;
  logic [10:0] acc_offset;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [3];

  always #2 clk = ~clk;

  data_addr_unit u_data_addr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_ptr(req_ptr), .req_disp(req_disp), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .fab_rdata(fab_rdata),
    .req_ready(req_ready), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wdata(acc_wdata), .acc_addr(acc_addr), .acc_sel(acc_sel),
    .acc_offset(acc_offset), .acc_oor(acc_oor), .stall(stall),
    .core_rdata(core_rdata), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cur_ptr(input int p);
    case (p)
      0: return ptr_x;
      1: return ptr_y;
      default: return ptr_z;
    endcase
  endfunction

  // issue one request at a falling edge; return at the next falling edge
  task automatic issue(input logic [2:0] m, input int p, input logic [5:0] d,
                       input logic [15:0] a, input logic w, input logic [7:0] wd);
    req_mode = m; req_ptr = 2'(p); req_disp = d; req_addr = a;
    req_write = w; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // run out a pending SRAM stall and check R10 / R11
  task automatic finish_stall(input logic [15:0] ea);
    if (ea >= 16'h0100 && ea < 16'h0900) begin
      chk(stall === 1'b1 && req_ready === 1'b0, "R10 stall raised", {30'd0, stall, req_ready}, 32'h2);
      req_addr = ~ea; req_mode = 3'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(acc_addr === ea && stall === 1'b0, "R10 held one cycle", {15'd0, stall, acc_addr}, {16'd0, ea});
    end else begin
      chk(stall === 1'b0, "R11 no stall", {31'd0, stall}, 32'd0);
    end
  endtask

  task automatic set_ptr(input int p, input logic [15:0] v);
    issue(3'd0, 0, 6'd0, 16'(26 + 2*p), 1'b1, v[7:0]);
    issue(3'd0, 0, 6'd0, 16'(27 + 2*p), 1'b1, v[15:8]);
    model[p] = v;
    chk(cur_ptr(p) === v, "R8 pointer load", {16'd0, cur_ptr(p)}, {16'd0, v});
  endtask

  task automatic check_decode(input logic [15:0] a);
    logic [3:0]  es;
    logic [10:0] eo;
    int ai;
    ai = int'(a);
    es = 4'd0; eo = 11'd0;
    if (ai < 32)        begin es = 4'b0001; eo = 11'(ai); end
    else if (ai < 96)   begin es = 4'b0010; eo = 11'(ai - 32); end
    else if (ai < 256)  begin es = 4'b0100; eo = 11'(ai - 96); end
    else if (ai < 2304) begin es = 4'b1000; eo = 11'(ai - 256); end
    if (es != 4'd0) begin
      chk(acc_sel === es && acc_offset === eo && acc_oor === 1'b0, "R1 decode",
          {acc_oor, acc_sel, acc_offset, acc_addr}, {1'b0, es, eo, a});
      chk(core_rdata === fab_rdata, "R2 read pass", {24'd0, core_rdata}, {24'd0, fab_rdata});
    end else begin
      chk(acc_sel === 4'd0 && acc_oor === 1'b1 && core_rdata === 8'd0, "R2 out of range",
          {19'd0, acc_oor, acc_sel, core_rdata}, {19'd0, 1'b1, 4'd0, 8'd0});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ptr_x === 16'd0 && ptr_y === 16'd0 && ptr_z === 16'd0, "R12 pointers", {16'd0, ptr_x | ptr_y | ptr_z}, 32'd0);
    chk(acc_valid === 1'b0 && acc_sel === 4'd0 && acc_oor === 1'b0 && stall === 1'b0, "R12 outputs",
        {25'd0, acc_valid, acc_sel, acc_oor, stall}, 32'd0);
    for (int i = 0; i < 3; i++) model[i] = 16'd0;

    // R3 / R1 / R2: direct read sweep over the whole mapped space and past it
    for (int a = 0; a <= 16'h0910; a++) begin
      fab_rdata = 8'(a * 7 + 3);
      issue(3'd0, a % 3, 6'(a), 16'(a), 1'b0, 8'd0);
      chk(acc_addr === 16'(a) && acc_valid === 1'b1, "R3 direct address", {16'd0, acc_addr}, a);
      check_decode(16'(a));
      finish_stall(16'(a));
    end
    foreach (model[i]) chk(cur_ptr(i) === 16'd0, "R3 pointers untouched", {16'd0, cur_ptr(i)}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] a;
      a = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h8000 : (k == 2) ? 16'h0900 : 16'h1000;
      issue(3'd0, 0, 6'd0, a, 1'b0, 8'd0);
      check_decode(a);
      finish_stall(a);
    end

    // pointer modes over boundary pointer values
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 7; k++) begin
        logic [15:0] b, e;
        case (k)
          0: b = 16'h0000; 1: b = 16'h0001; 2: b = 16'h00FF; 3: b = 16'h0100;
          4: b = 16'h08FF; 5: b = 16'hFFFF; default: b = 16'h1234;
        endcase
        set_ptr(p, b);
        issue(3'd1, p, 6'd0, 16'h0000, 1'b0, 8'd0);
        chk(acc_addr === b && cur_ptr(p) === b, "R4 indirect", {acc_addr, cur_ptr(p)}, {b, b});
        check_decode(b);
        finish_stall(b);
        for (int d = 0; d < 64; d += 9) begin
          logic [5:0] dd;
          dd = (d > 60) ? 6'd63 : 6'(d);
          e = (p == 0) ? b : b + 16'(dd);
          issue(3'd2, p, dd, 16'h0000, 1'b0, 8'd0);
          chk(acc_addr === e && cur_ptr(p) === b, "R5 displacement", {acc_addr, cur_ptr(p)}, {e, b});
          finish_stall(e);
        end
        issue(3'd2, p, 6'd63, 16'h0000, 1'b0, 8'd0);
        e = (p == 0) ? b : b + 16'd63;
        chk(acc_addr === e, "R5 max displacement", {16'd0, acc_addr}, {16'd0, e});
        finish_stall(e);
        e = b - 16'd1;
        issue(3'd3, p, 6'd0, 16'h0000, 1'b0, 8'd0);
        chk(acc_addr === e && cur_ptr(p) === e, "R6 pre-decrement", {acc_addr, cur_ptr(p)}, {e, e});
        finish_stall(e);
        set_ptr(p, b);
        e = b + 16'd1;
        issue(3'd4, p, 6'd0, 16'h0000, 1'b0, 8'd0);
        chk(acc_addr === b && cur_ptr(p) === e, "R7 post-increment", {acc_addr, cur_ptr(p)}, {b, e});
        finish_stall(b);
        set_ptr(p, 16'h0000);
      end
    end

    // R8: indirect store through X into Y low byte
    set_ptr(1, 16'hAB00);
    set_ptr(0, 16'h001C);
    issue(3'd1, 0, 6'd0, 16'h0000, 1'b1, 8'h77);
    chk(ptr_y === 16'hAB77 && ptr_x === 16'h001C, "R8 store via pointer", {ptr_y, ptr_x}, {16'hAB77, 16'h001C});

    // R9: post-increment store onto its own low byte; write-back wins
    set_ptr(0, 16'h001A);
    issue(3'd4, 0, 6'd0, 16'h0000, 1'b1, 8'h55);
    chk(ptr_x === 16'h001B, "R9 write-back wins", {16'd0, ptr_x}, 32'h001B);
    // R9: pre-decrement store onto its own high byte
    set_ptr(2, 16'h0020);
    issue(3'd3, 2, 6'd0, 16'h0000, 1'b1, 8'hEE);
    chk(ptr_z === 16'h001F, "R9 write-back over high byte", {16'd0, ptr_z}, 32'h001F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule